// File: doc/BRIEF.md
# Multicast Mesh Crosspoint Router

This block is one router node of a two-dimensional mesh network on chip. It carries a single message class on its own physical network, so that traffic of one class never waits behind another class. The node has four mesh ports (north, east, south, west) and four local ports that attach two requester agents and two home agents. Every flit carries a one-hot destination vector with one bit per endpoint in the whole mesh, so a single flit can address any set of endpoints.

Each input port buffers flits in a small FIFO with valid/ready flow control. A per-input route table maps each destination node to an output. From that table the input builds, for every output, the subset of the destination vector reached through that output. A copy leaves on an output only when its subset is non-empty, and it carries only that subset. Multicast flits are therefore split inside the router, and each link carries one copy. The table resets to X-then-Y dimension-ordered routes and can be rewritten per input for turn-model routes. Each output picks among inputs with a round-robin arbiter.

Top module: `xp_mesh_node`

## Requirements
- R1: After reset no output is valid and every input is ready.
- R2: Endpoint index is node*4+local, node = y*MESH_X+x; ports are numbered north 0, east 1, south 2, west 3, local 4..7. With the reset table a destination with larger x leaves east, smaller x west; with equal x, larger y leaves north and smaller y south.
- R3: A destination bit of this node's local endpoint k is delivered on port 4+k, and that copy carries exactly that one bit.
- R4: Each output copy carries only the destination bits its route covers, and an output with no covered bit stays idle.
- R5: One input flit yields copies on all covered outputs in the same cycle when they are ready, and each output sends exactly one copy per flit.
- R6: A flit leaves its input FIFO only after every required output has accepted its copy; the next flit of that input is not presented before that.
- R7: Each output serves competing inputs round-robin: after a grant to input i, priority starts at input i+1; after reset it starts at input 0.
- R8: While an output is valid and not ready, its grant, destination bits and payload stay unchanged.
- R9: Writing a route table entry (cfg_we, cfg_port, cfg_node, cfg_route with 0..3 the mesh ports and 4 meaning this node) changes routing for that input only.
- R10: A flit with an all-zero destination vector is discarded without any output copy.
- R11: Each input FIFO holds FIFO_DEPTH flits in order and deasserts ready while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | NPORT | Per-input flit valid |
| in_ready | output | NPORT | Per-input FIFO has space |
| in_dest | input | NPORT x DEST_W | Per-input one-hot destination vector |
| in_data | input | NPORT x PAY_W | Per-input payload |
| out_valid | output | NPORT | Per-output copy valid |
| out_ready | input | NPORT | Per-output downstream ready |
| out_dest | output | NPORT x DEST_W | Per-output masked destination vector |
| out_data | output | NPORT x PAY_W | Per-output payload |
| cfg_we | input | 1 | Route table write enable |
| cfg_port | input | PORT_W | Input whose table is written |
| cfg_node | input | NODE_W | Destination node of the entry |
| cfg_route | input | 3 | New route code (0..3 mesh port, 4 local) |

## Verification
The bench builds a 3x3 mesh with the node at the centre (1,1), four local endpoints and a FIFO depth of two. The centre position gives every mesh direction a real route under the reset table, so one multicast vector can fan out to north, east, west and two local ports at once. The shallow FIFO makes the full condition reachable in two pushes, and the small vector width keeps each expected destination subset easy to compute by hand.

// File: rtl/xp_pkg.sv
package xp_pkg;

  localparam int unsigned MESH_DIRS = 4;

  typedef enum logic [2:0] {
    DIR_N    = 3'd0,
    DIR_E    = 3'd1,
    DIR_S    = 3'd2,
    DIR_W    = 3'd3,
    DIR_HERE = 3'd4
  } route_e;

  // X first, then Y; north is increasing y.
  function automatic route_e xy_route(input int unsigned my_x, input int unsigned my_y,
                                      input int unsigned dx, input int unsigned dy);
    if (dx > my_x) return DIR_E;
    if (dx < my_x) return DIR_W;
    if (dy > my_y) return DIR_N;
    if (dy < my_y) return DIR_S;
    return DIR_HERE;
  endfunction

endpackage

// File: rtl/xp_in_fifo.sv
module xp_in_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [WIDTH-1:0] push_flit,
  output logic             head_valid,
  input  logic             head_pop,
  output logic [WIDTH-1:0] head_flit
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push, pop;

  assign push_ready = (cnt_q != CW'(DEPTH));
  assign head_valid = (cnt_q != '0);
  assign push       = push_valid && push_ready;
  assign pop        = head_valid && head_pop;
  assign head_flit  = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_flit;
  end

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  p_full_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH)) && !pop |=> cnt_q == CW'(DEPTH));

endmodule

// File: rtl/xp_route.sv
module xp_route
  import xp_pkg::*;
#(
  parameter int unsigned MESH_X = 8,
  parameter int unsigned MESH_Y = 8,
  parameter int unsigned MY_X   = 0,
  parameter int unsigned MY_Y   = 0,
  parameter int unsigned LOCALS = 4,
  localparam int unsigned NODES  = MESH_X * MESH_Y,
  localparam int unsigned DEST_W = NODES * LOCALS,
  localparam int unsigned NPORT  = MESH_DIRS + LOCALS,
  localparam int unsigned NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tbl_we,
  input  logic [NODE_W-1:0]                 tbl_node,
  input  logic [2:0]                        tbl_route,
  input  logic [DEST_W-1:0]                 dest,
  output logic [NPORT-1:0][DEST_W-1:0]      mask
);
  logic [2:0] tbl_q [NODES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NODES; n++)
        tbl_q[n] <= xy_route(MY_X, MY_Y, n % MESH_X, n / MESH_X);
    end else if (tbl_we) begin
      tbl_q[tbl_node] <= tbl_route;
    end
  end

  // Split the destination vector into per-output subsets.
  always_comb begin
    mask = '0;
    for (int n = 0; n < NODES; n++) begin
      for (int l = 0; l < LOCALS; l++) begin
        if (tbl_q[n] == 3'(DIR_HERE))
          mask[MESH_DIRS + l][n*LOCALS + l] = dest[n*LOCALS + l];
        else if (tbl_q[n] < 3'(DIR_HERE))
          mask[tbl_q[n][1:0]][n*LOCALS + l] = dest[n*LOCALS + l];
      end
    end
  end

endmodule

// File: rtl/xp_rr_arb.sv
module xp_rr_arb #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         stall,
  input  logic         take,
  output logic [N-1:0] grant
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, ptr_d;
  logic [N-1:0]  held_q, held_d, pick;
  logic          lock_q, lock_d;

  always_comb begin : pick_c
    int unsigned idx;
    pick = '0;
    for (int k = 0; k < N; k++) begin
      idx = (32'(ptr_q) + 32'(k)) % N;
      if (pick == '0 && req[idx]) pick[idx] = 1'b1;
    end
  end

  assign grant = lock_q ? held_q : pick;

  always_comb begin
    ptr_d  = ptr_q;
    held_d = held_q;
    lock_d = stall;
    if (stall) held_d = grant;
    if (take) begin
      for (int k = 0; k < N; k++)
        if (grant[k]) ptr_d = (k == N - 1) ? '0 : IW'(k + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      held_q <= '0;
      lock_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      held_q <= held_d;
      lock_q <= lock_d;
    end
  end

  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_has_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

  p_grant_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> grant == $past(grant));

endmodule

// File: rtl/xp_mesh_node.sv
module xp_mesh_node
  import xp_pkg::*;
#(
  parameter int unsigned MESH_X     = 8,
  parameter int unsigned MESH_Y     = 8,
  parameter int unsigned MY_X       = 0,
  parameter int unsigned MY_Y       = 0,
  parameter int unsigned LOCALS     = 4,
  parameter int unsigned PAY_W      = 32,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned NODES  = MESH_X * MESH_Y,
  localparam int unsigned DEST_W = NODES * LOCALS,
  localparam int unsigned NPORT  = MESH_DIRS + LOCALS,
  localparam int unsigned PORT_W = $clog2(NPORT),
  localparam int unsigned NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             in_valid,
  output logic [NPORT-1:0]             in_ready,
  input  logic [NPORT-1:0][DEST_W-1:0] in_dest,
  input  logic [NPORT-1:0][PAY_W-1:0]  in_data,
  output logic [NPORT-1:0]             out_valid,
  input  logic [NPORT-1:0]             out_ready,
  output logic [NPORT-1:0][DEST_W-1:0] out_dest,
  output logic [NPORT-1:0][PAY_W-1:0]  out_data,
  input  logic                         cfg_we,
  input  logic [PORT_W-1:0]            cfg_port,
  input  logic [NODE_W-1:0]            cfg_node,
  input  logic [2:0]                   cfg_route
);
  localparam int unsigned FLIT_W = DEST_W + PAY_W;

  logic [1:0] rsync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  logic [NPORT-1:0]                 head_valid, pop;
  logic [FLIT_W-1:0]                head_flit [NPORT];
  logic [NPORT-1:0][DEST_W-1:0]     mask_w    [NPORT];   // [input][output]
  logic [NPORT-1:0]                 need      [NPORT];   // [input][output]
  logic [NPORT-1:0]                 req_t     [NPORT];   // [output][input]
  logic [NPORT-1:0]                 grant     [NPORT];   // [output][input]
  logic [NPORT-1:0]                 fire_t    [NPORT];   // [input][output]
  logic [NPORT-1:0]                 sent_q    [NPORT];
  logic [NPORT-1:0]                 sent_d    [NPORT];
  logic [NPORT-1:0]                 fire;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    xp_in_fifo #(.WIDTH(FLIT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk        (clk),
      .rst_n      (rst_s),
      .push_valid (in_valid[i]),
      .push_ready (in_ready[i]),
      .push_flit  ({in_dest[i], in_data[i]}),
      .head_valid (head_valid[i]),
      .head_pop   (pop[i]),
      .head_flit  (head_flit[i])
    );

    xp_route #(.MESH_X(MESH_X), .MESH_Y(MESH_Y), .MY_X(MY_X), .MY_Y(MY_Y),
               .LOCALS(LOCALS)) i_route (
      .clk       (clk),
      .rst_n     (rst_s),
      .tbl_we    (cfg_we && (cfg_port == PORT_W'(i))),
      .tbl_node  (cfg_node),
      .tbl_route (cfg_route),
      .dest      (head_flit[i][FLIT_W-1:PAY_W]),
      .mask      (mask_w[i])
    );
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    xp_rr_arb #(.N(NPORT)) i_arb (
      .clk   (clk),
      .rst_n (rst_s),
      .req   (req_t[o]),
      .stall (out_valid[o] && !out_ready[o]),
      .take  (fire[o]),
      .grant (grant[o])
    );
    assign out_valid[o] = |grant[o];
    assign fire[o]      = out_valid[o] && out_ready[o];

    p_hold_copy_r8: assert property (@(posedge clk) disable iff (!rst_s)
      out_valid[o] && !out_ready[o] |=>
        out_valid[o] && $stable(out_dest[o]) && $stable(out_data[o]));

    p_nonempty_copy_r4: assert property (@(posedge clk) disable iff (!rst_s)
      out_valid[o] |-> out_dest[o] != '0);

    if (o >= MESH_DIRS) begin : g_loc
      p_single_local_bit_r3: assert property (@(posedge clk) disable iff (!rst_s)
        out_valid[o] |-> $countones(out_dest[o]) == 1);
    end
  end

  // Outstanding copies per input head and output.
  always_comb begin
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        need[i][o] = head_valid[i] && (mask_w[i][o] != '0) && !sent_q[i][o];
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req_t[o][i] = need[i][o];
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        fire_t[i][o] = fire[o] && grant[o][i];
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      out_dest[o] = '0;
      out_data[o] = '0;
      for (int i = 0; i < NPORT; i++) begin
        if (grant[o][i]) begin
          out_dest[o] = out_dest[o] | mask_w[i][o];
          out_data[o] = out_data[o] | head_flit[i][PAY_W-1:0];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      pop[i]    = head_valid[i] && ((need[i] & ~fire_t[i]) == '0);
      sent_d[i] = pop[i] ? '0 : (sent_q[i] | fire_t[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      for (int i = 0; i < NPORT; i++) sent_q[i] <= '0;
    end else begin
      for (int i = 0; i < NPORT; i++) sent_q[i] <= sent_d[i];
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    p_pop_after_all_r6: assert property (@(posedge clk) disable iff (!rst_s)
      head_valid[i] && !pop[i] |=> head_valid[i]);
  end

endmodule

// File: tb/test_xp_mesh_node.sv
`timescale 1ns/1ps
module test_xp_mesh_node;
  localparam int MX = 3, MY = 3, LOC = 4, PW = 16, DEPTH = 2;
  localparam int NP = 8, DW = MX * MY * LOC;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic [NP-1:0]         in_valid, in_ready, out_valid, out_ready;
  logic [NP-1:0][DW-1:0] in_dest, out_dest;
  logic [NP-1:0][PW-1:0] in_data, out_data;
  logic                  cfg_we;
  logic [2:0]            cfg_port;
  logic [3:0]            cfg_node;
  logic [2:0]            cfg_route;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xp_mesh_node #(.MESH_X(MX), .MESH_Y(MY), .MY_X(1), .MY_Y(1), .LOCALS(LOC),
                 .PAY_W(PW), .FIFO_DEPTH(DEPTH)) i_xp_mesh_node (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_dest(out_dest), .out_data(out_data),
    .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_node(cfg_node), .cfg_route(cfg_route));

  function automatic logic [DW-1:0] bv(int x, int y, int l);
    return DW'(1) << ((y * MX + x) * LOC + l);
  endfunction

  task automatic check(logic [63:0] act, logic [63:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = '0; in_dest = '0; in_data = '0; out_ready = '1;
    cfg_we = 1'b0; cfg_port = '0; cfg_node = '0; cfg_route = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Called at a negedge; returns at the next negedge with the flit pushed.
  task automatic send(int p, logic [DW-1:0] d, logic [PW-1:0] v);
    in_valid[p] = 1'b1; in_dest[p] = d; in_data[p] = v;
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  task automatic t_reset();
    check(64'(out_valid), 64'h0, "R1 outputs idle after reset");
    check(64'(in_ready), 64'hff, "R1 inputs ready after reset");
  endtask

  task automatic t_unicast();
    out_ready = '1;
    send(3, bv(2, 0, 1), 16'h1001);
    check(64'(out_valid), 64'h02, "R2 larger x leaves east");
    check(64'(out_dest[1]), 64'(bv(2, 0, 1)), "R2 east copy bits");
    @(negedge clk);
    check(64'(out_valid), 64'h00, "R5 single copy sent once");
    send(1, bv(0, 2, 0), 16'h1002);
    check(64'(out_valid), 64'h08, "R2 smaller x leaves west");
    @(negedge clk);
    send(3, bv(1, 2, 3), 16'h1003);
    check(64'(out_valid), 64'h01, "R2 equal x larger y leaves north");
    @(negedge clk);
    send(0, bv(1, 0, 2), 16'h1004);
    check(64'(out_valid), 64'h04, "R2 equal x smaller y leaves south");
    @(negedge clk);
    send(2, bv(1, 1, 2), 16'h1005);
    check(64'(out_valid), 64'h40, "R3 local endpoint 2 on port 6");
    check(64'(out_data[6]), 64'h1005, "R3 local payload");
    @(negedge clk);
  endtask

  task automatic t_multicast();
    logic [DW-1:0] d;
    out_ready = '1;
    d = bv(1, 1, 0) | bv(1, 1, 3) | bv(2, 2, 0) | bv(2, 0, 3) | bv(1, 2, 1) | bv(0, 1, 2);
    send(3, d, 16'h2000);
    check(64'(out_valid), 64'h9b, "R5 copies on all covered outputs");
    check(64'(out_dest[4]), 64'(bv(1, 1, 0)), "R3 local 0 single bit");
    check(64'(out_dest[7]), 64'(bv(1, 1, 3)), "R3 local 3 single bit");
    check(64'(out_dest[1]), 64'(bv(2, 2, 0) | bv(2, 0, 3)), "R4 east subset");
    check(64'(out_dest[0]), 64'(bv(1, 2, 1)), "R4 north subset");
    check(64'(out_dest[3]), 64'(bv(0, 1, 2)), "R4 west subset");
    check(64'(out_data[3]), 64'h2000, "R5 payload replicated");
    @(negedge clk);
    check(64'(out_valid), 64'h00, "R5 no repeat copies");
  endtask

  task automatic t_backpressure();
    out_ready = '1; out_ready[1] = 1'b0;
    send(2, bv(2, 1, 0) | bv(1, 2, 0), 16'h3001);
    check(64'(out_valid), 64'h03, "R5 north and east copies");
    send(2, bv(1, 2, 1), 16'h3002);
    check(64'(out_valid), 64'h02, "R6 next flit held behind pending copy");
    check(64'(out_dest[1]), 64'(bv(2, 1, 0)), "R8 east copy bits held");
    @(negedge clk);
    check(64'(out_dest[1]), 64'(bv(2, 1, 0)), "R8 east copy still held");
    check(64'(out_data[1]), 64'h3001, "R8 payload held");
    out_ready[1] = 1'b1;
    @(negedge clk);
    check(64'(out_valid), 64'h01, "R6 next flit after all copies taken");
    check(64'(out_data[0]), 64'h3002, "R6 next flit payload");
    @(negedge clk);
    check(64'(out_valid), 64'h00, "R6 drained");
  endtask

  task automatic t_round_robin();
    do_reset();
    out_ready[1] = 1'b0;
    for (int k = 0; k < 2; k++) begin
      in_valid[0] = 1'b1; in_dest[0] = bv(2, 1, 0); in_data[0] = 16'hA000 + 16'(k);
      in_valid[2] = 1'b1; in_dest[2] = bv(2, 1, 0); in_data[2] = 16'hB000 + 16'(k);
      @(negedge clk);
    end
    in_valid = '0;
    check(64'(out_data[1]), 64'hA000, "R7 input 0 first after reset");
    out_ready[1] = 1'b1;
    @(negedge clk);
    check(64'(out_data[1]), 64'hB000, "R7 input 2 next");
    @(negedge clk);
    check(64'(out_data[1]), 64'hA001, "R7 back to input 0");
    @(negedge clk);
    check(64'(out_data[1]), 64'hB001, "R7 then input 2");
    @(negedge clk);
    check(64'(out_valid), 64'h00, "R7 all served");
  endtask

  task automatic t_table();
    out_ready = '1;
    cfg_we = 1'b1; cfg_port = 3'd0; cfg_node = 4'd8; cfg_route = 3'd0;
    @(negedge clk);
    cfg_we = 1'b0;
    send(0, bv(2, 2, 1), 16'h4001);
    check(64'(out_valid), 64'h01, "R9 rewritten entry routes north");
    @(negedge clk);
    send(1, bv(2, 2, 1), 16'h4002);
    check(64'(out_valid), 64'h02, "R9 other input keeps east");
    @(negedge clk);
  endtask

  task automatic t_zero();
    out_ready = '1;
    send(5, '0, 16'h5001);
    check(64'(out_valid), 64'h00, "R10 empty vector gives no copy");
    @(negedge clk);
    check(64'(in_ready[5]), 64'h1, "R10 empty flit drained");
    send(5, bv(1, 1, 1), 16'h5002);
    check(64'(out_valid), 64'h20, "R10 following flit delivered");
    check(64'(out_data[5]), 64'h5002, "R10 following payload");
    @(negedge clk);
  endtask

  task automatic t_full();
    out_ready = '0;
    send(4, bv(0, 1, 0), 16'h6000);
    send(4, bv(0, 1, 0), 16'h6001);
    check(64'(in_ready[4]), 64'h0, "R11 ready low when full");
    send(4, bv(0, 1, 0), 16'h6002);
    out_ready[3] = 1'b1;
    check(64'(out_data[3]), 64'h6000, "R11 first in order");
    @(negedge clk);
    check(64'(out_data[3]), 64'h6001, "R11 second in order");
    @(negedge clk);
    check(64'(out_valid), 64'h00, "R11 refused flit not stored");
    out_ready = '1;
  endtask

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_unicast();
    t_multicast();
    t_backpressure();
    t_round_robin();
    t_table();
    t_zero();
    t_full();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule